// File: doc/BRIEF.md
# Grid-Aligned Random Apple Placer

This block picks the cell where the next apple appears on a tile-based snake playfield. A 20-bit linear feedback shift register runs freely, one step per clock. Two separate bit fields of its state become a column and a row candidate. Each field is folded into the interior of the board, so a candidate is always a whole cell and never touches the border wall.

While it searches, the block presents every candidate as a cell query to the snake controller. That controller answers in the same cycle whether the snake occupies the cell. An occupied candidate is dropped, and the next cycle's candidate is tried. The first free candidate is latched as the apple and the valid flag rises.

A reset always starts a new search. After that, a new search starts only on a request pulse that arrives while the game is running, which is how an eaten apple is replaced.

Top module: `apple_placer`

## Requirements
- R1: The random source is a 20-bit register that is loaded with SEED (default 20'h5A5A5, and 1 if SEED is given as zero) during reset. Every clock outside reset it steps to {s[18:0], s[19]^s[16]}, so its state is never zero.
- R2: The column candidate is WALL + f(s[XB-1:0]) and the row candidate is WALL + f(s[19:20-YB]). Here XB and YB are the ceiling log2 of the interior spans GRID_W-2*WALL and GRID_H-2*WALL. f subtracts the span once when the raw value is at least the span. With the defaults the spans are 38 and 28 and the field widths are 6 and 5.
- R3: While apple_vld is high, apple_x lies in WALL..GRID_W-1-WALL and apple_y lies in WALL..GRID_H-1-WALL.
- R4: A candidate is accepted only in a cycle where occ_i is low. An occupied candidate is discarded, and the candidate derived from the next register state is queried on the following clock.
- R5: While reset is high and in the cycle after it, apple_vld is low. If the first candidate after reset release is free, apple_vld is high one clock after reset falls.
- R6: If req_i and run_i are both high while apple_vld is high, apple_vld is low after the next clock and a new search begins.
- R7: A req_i pulse with run_i low leaves apple_vld, apple_x and apple_y unchanged.
- R8: While apple_vld is high and no request is honoured, apple_x and apple_y hold their values.
- R9: Outside reset, qry_vld is high exactly when apple_vld is low, and it carries the current candidate on qry_x and qry_y. An accepted candidate appears on apple_x and apple_y, with apple_vld high, one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request for a new apple |
| run_i | input | 1 | Game is in its running state |
| occ_i | input | 1 | Snake occupies the queried cell (same-cycle answer) |
| qry_x | output | $clog2(GRID_W) | Candidate column under query |
| qry_y | output | $clog2(GRID_H) | Candidate row under query |
| qry_vld | output | 1 | A candidate is being queried |
| apple_x | output | $clog2(GRID_W) | Apple column |
| apple_y | output | $clog2(GRID_H) | Apple row |
| apple_vld | output | 1 | Apple position is valid |

## Verification
The first pattern is an empty board. Here the first candidate after reset or a request must be taken at once, which pins down the acceptance latency and the field mapping.

The second pattern occupies a large block of columns. This forces chains of rejections, so it separates a design that redraws on the next clock from one that stalls or accepts occupied cells.

The third pattern leaves a single free cell, which proves that the search keeps going until that cell turns up. Request pulses with run_i low, request pulses with run_i high, and a reset during a held apple separate the ignored request from the honoured request and from the reset path.

// File: rtl/apl_pkg.sv
package apl_pkg;

  localparam int LFSR_W = 20;

  typedef enum logic [0:0] {
    ST_SEEK = 1'b0,
    ST_HOLD = 1'b1
  } apl_state_e;

  // One maximal-length step, feedback from the x^20 and x^17 taps.
  function automatic logic [LFSR_W-1:0] apl_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[16]};
  endfunction

  // Fold a raw field into 0..span-1. One subtraction suffices, because the
  // field is only as wide as the span needs.
  function automatic int apl_fold(input int raw, input int span);
    return (raw >= span) ? raw - span : raw;
  endfunction

  function automatic int apl_bits(input int span);
    return (span > 1) ? $clog2(span) : 1;
  endfunction

endpackage

// File: rtl/apl_lfsr.sv
module apl_lfsr
  import apl_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 20'h5A5A5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] state_o
);

  logic [LFSR_W-1:0] s_q;

  // A zero seed would lock the register, so a zero SEED selects 1 instead.
  generate
    if (SEED == '0) begin : g_seed_fix
      localparam logic [LFSR_W-1:0] SEED_USE = LFSR_W'(1);
      always_ff @(posedge clk) begin
        if (rst) s_q <= SEED_USE;
        else     s_q <= apl_step(s_q);
      end
    end else begin : g_seed_given
      always_ff @(posedge clk) begin
        if (rst) s_q <= SEED;
        else     s_q <= apl_step(s_q);
      end
    end
  endgenerate

  assign state_o = s_q;

endmodule

// File: rtl/apl_cand.sv
module apl_cand
  import apl_pkg::*;
#(
  parameter int GRID = 40,
  parameter int WALL = 1,
  localparam int SPAN = GRID - 2 * WALL,
  localparam int FB   = apl_bits(SPAN),
  localparam int CW   = $clog2(GRID)
) (
  input  logic [FB-1:0] raw_i,
  output logic [CW-1:0] cell_o
);

  int folded;

  always_comb begin
    folded = apl_fold(int'(raw_i), SPAN);
    cell_o = CW'(WALL + folded);
  end

endmodule

// File: rtl/apl_ctrl.sv
module apl_ctrl
  import apl_pkg::*;
#(
  parameter int CW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          run_i,
  input  logic          occ_i,
  input  logic [CW-1:0] cand_x_i,
  input  logic [RW-1:0] cand_y_i,
  output logic          seek_o,
  output logic          accept_o,
  output logic          rearm_o,
  output logic [CW-1:0] apple_x_o,
  output logic [RW-1:0] apple_y_o,
  output logic          apple_vld_o
);

  apl_state_e st_q;
  logic [CW-1:0] ax_q;
  logic [RW-1:0] ay_q;
  logic          vld_q;

  assign seek_o   = (st_q == ST_SEEK);
  assign accept_o = seek_o && !occ_i;
  assign rearm_o  = (st_q == ST_HOLD) && req_i && run_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_SEEK;
      vld_q <= 1'b0;
      ax_q  <= '0;
      ay_q  <= '0;
    end else begin
      if (accept_o) begin
        st_q  <= ST_HOLD;
        vld_q <= 1'b1;
        ax_q  <= cand_x_i;
        ay_q  <= cand_y_i;
      end else if (rearm_o) begin
        st_q  <= ST_SEEK;
        vld_q <= 1'b0;
      end
    end
  end

  assign apple_x_o   = ax_q;
  assign apple_y_o   = ay_q;
  assign apple_vld_o = vld_q;

endmodule

// File: rtl/apple_placer.sv
module apple_placer
  import apl_pkg::*;
#(
  parameter int                GRID_W = 40,
  parameter int                GRID_H = 30,
  parameter int                WALL   = 1,
  parameter logic [LFSR_W-1:0] SEED   = 20'h5A5A5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_i,
  input  logic                      run_i,
  input  logic                      occ_i,
  output logic [$clog2(GRID_W)-1:0] qry_x,
  output logic [$clog2(GRID_H)-1:0] qry_y,
  output logic                      qry_vld,
  output logic [$clog2(GRID_W)-1:0] apple_x,
  output logic [$clog2(GRID_H)-1:0] apple_y,
  output logic                      apple_vld
);

  localparam int CW     = $clog2(GRID_W);
  localparam int RW     = $clog2(GRID_H);
  localparam int SPAN_X = GRID_W - 2 * WALL;
  localparam int SPAN_Y = GRID_H - 2 * WALL;
  localparam int XB     = apl_bits(SPAN_X);
  localparam int YB     = apl_bits(SPAN_Y);

  // Named internal events, brought out for the checker.
  logic [LFSR_W-1:0] lfsr_w;
  logic [CW-1:0]     cand_x_w;
  logic [RW-1:0]     cand_y_w;
  logic              accept_w;
  logic              rearm_w;

  apl_lfsr #(.SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .state_o (lfsr_w)
  );

  // Column field from the low bits, row field from the high bits.
  apl_cand #(.GRID(GRID_W), .WALL(WALL)) u_cand_x (
    .raw_i  (lfsr_w[XB-1:0]),
    .cell_o (cand_x_w)
  );

  apl_cand #(.GRID(GRID_H), .WALL(WALL)) u_cand_y (
    .raw_i  (lfsr_w[LFSR_W-1 -: YB]),
    .cell_o (cand_y_w)
  );

  apl_ctrl #(.CW(CW), .RW(RW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .run_i       (run_i),
    .occ_i       (occ_i),
    .cand_x_i    (cand_x_w),
    .cand_y_i    (cand_y_w),
    .seek_o      (qry_vld),
    .accept_o    (accept_w),
    .rearm_o     (rearm_w),
    .apple_x_o   (apple_x),
    .apple_y_o   (apple_y),
    .apple_vld_o (apple_vld)
  );

  assign qry_x = cand_x_w;
  assign qry_y = cand_y_w;

endmodule

// File: rtl/apl_chk.sv
module apl_chk #(
  parameter int GRID_W = 40,
  parameter int GRID_H = 30,
  parameter int WALL   = 1,
  localparam int CW    = $clog2(GRID_W),
  localparam int RW    = $clog2(GRID_H)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic          run_i,
  input logic          occ_i,
  input logic [CW-1:0] qry_x,
  input logic [RW-1:0] qry_y,
  input logic          qry_vld,
  input logic [CW-1:0] apple_x,
  input logic [RW-1:0] apple_y,
  input logic          apple_vld,
  input logic [19:0]   lfsr_w,
  input logic          accept_w,
  input logic          rearm_w
);

  localparam logic [CW-1:0] X_LO = CW'(WALL);
  localparam logic [CW-1:0] X_HI = CW'(GRID_W - 1 - WALL);
  localparam logic [RW-1:0] Y_LO = RW'(WALL);
  localparam logic [RW-1:0] Y_HI = RW'(GRID_H - 1 - WALL);

  assert_lfsr_live_R1: assert property (@(posedge clk) disable iff (rst)
    lfsr_w != 20'd0);

  assert_inside_R3: assert property (@(posedge clk) disable iff (rst)
    apple_vld |-> (apple_x >= X_LO && apple_x <= X_HI &&
                   apple_y >= Y_LO && apple_y <= Y_HI));

  assert_free_cell_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(apple_vld) |-> $past(qry_vld && !occ_i));

  assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
    rearm_w |=> !apple_vld);

  assert_honour_R6: assert property (@(posedge clk) disable iff (rst)
    (apple_vld && req_i && run_i) |=> !apple_vld);

  assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (apple_vld && req_i && !run_i) |=> apple_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (apple_vld && !(req_i && run_i)) |=>
      (apple_vld && $stable(apple_x) && $stable(apple_y)));

  assert_latch_R9: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> (apple_vld && apple_x == $past(qry_x) && apple_y == $past(qry_y)));

  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    qry_vld != apple_vld);

endmodule

bind apple_placer apl_chk #(.GRID_W(GRID_W), .GRID_H(GRID_H), .WALL(WALL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .run_i     (run_i),
  .occ_i     (occ_i),
  .qry_x     (qry_x),
  .qry_y     (qry_y),
  .qry_vld   (qry_vld),
  .apple_x   (apple_x),
  .apple_y   (apple_y),
  .apple_vld (apple_vld),
  .lfsr_w    (lfsr_w),
  .accept_w  (accept_w),
  .rearm_w   (rearm_w)
);

// File: tb/apple_placer_tb.sv
`timescale 1ns/1ps
module apple_placer_tb;

  localparam int GW   = 40;
  localparam int GH   = 30;
  localparam int SEED = 'h5A5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0;
  logic run_i = 1'b0;
  logic occ_i;
  logic [5:0] qry_x, apple_x;
  logic [4:0] qry_y, apple_y;
  logic qry_vld, apple_vld;

  bit occ_map [0:GW*GH-1];
  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  apple_placer u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .run_i(run_i), .occ_i(occ_i),
    .qry_x(qry_x), .qry_y(qry_y), .qry_vld(qry_vld),
    .apple_x(apple_x), .apple_y(apple_y), .apple_vld(apple_vld)
  );

  // Snake controller stand-in: same-cycle occupancy answer.
  always_comb begin
    if (int'(qry_x) < GW && int'(qry_y) < GH) occ_i = occ_map[int'(qry_x) * GH + int'(qry_y)];
    else occ_i = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, written from the requirements.
  int  m_lfsr = SEED;
  bit  m_seek = 1'b1;
  bit  m_vld  = 1'b0;
  int  m_ax = 0, m_ay = 0;

  function automatic int ref_next(input int v);
    int fb;
    fb = ((v >> 19) ^ (v >> 16)) & 1;
    return ((v << 1) | fb) & 'hFFFFF;
  endfunction

  function automatic int ref_col(input int v);
    int r;
    r = v & 63;
    if (r >= 38) r = r - 38;
    return 1 + r;
  endfunction

  function automatic int ref_row(input int v);
    int r;
    r = (v >> 15) & 31;
    if (r >= 28) r = r - 28;
    return 1 + r;
  endfunction

  always @(posedge clk) begin
    int cx, cy;
    if (rst) begin
      m_lfsr = SEED; m_seek = 1'b1; m_vld = 1'b0;
    end else begin
      cx = ref_col(m_lfsr);
      cy = ref_row(m_lfsr);
      if (m_seek) begin
        if (!occ_map[cx * GH + cy]) begin
          m_ax = cx; m_ay = cy; m_vld = 1'b1; m_seek = 1'b0;
        end
      end else if (req_i && run_i) begin
        m_seek = 1'b1; m_vld = 1'b0;
      end
      m_lfsr = ref_next(m_lfsr);
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(apple_vld === m_vld, "R5/R6 apple_vld vs model", int'(apple_vld), int'(m_vld));
      if (m_vld) begin
        chk(int'(apple_x) == m_ax, "R2 apple_x vs model", int'(apple_x), m_ax);
        chk(int'(apple_y) == m_ay, "R2 apple_y vs model", int'(apple_y), m_ay);
      end
      if (!rst) begin
        chk(qry_vld === m_seek, "R9 qry_vld vs model", int'(qry_vld), int'(m_seek));
        chk(qry_vld !== apple_vld, "R9 qry_vld excludes apple_vld", int'(qry_vld), int'(!apple_vld));
        if (m_seek) begin
          chk(int'(qry_x) == ref_col(m_lfsr), "R1 candidate column", int'(qry_x), ref_col(m_lfsr));
          chk(int'(qry_y) == ref_row(m_lfsr), "R1 candidate row", int'(qry_y), ref_row(m_lfsr));
        end
      end
      if (apple_vld === 1'b1) begin
        chk(int'(apple_x) >= 1 && int'(apple_x) <= 38, "R3 apple_x in interior", int'(apple_x), 1);
        chk(int'(apple_y) >= 1 && int'(apple_y) <= 28, "R3 apple_y in interior", int'(apple_y), 1);
      end
    end
  end

  task automatic wait_vld(input int limit, input string tag);
    int n = 0;
    while (apple_vld !== 1'b1 && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(apple_vld === 1'b1, tag, int'(apple_vld), 1);
  endtask

  task automatic clear_map();
    for (int i = 0; i < GW * GH; i++) occ_map[i] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int sx, sy;
    clear_map();
    @(negedge clk);
    @(negedge clk);
    cmp_en = 1'b1;
    @(negedge clk);
    chk(apple_vld === 1'b0, "R5 apple_vld low in reset", int'(apple_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(apple_vld === 1'b1, "R5 apple one clock after reset on empty board", int'(apple_vld), 1);

    // R7: request while not running is ignored.
    sx = int'(apple_x); sy = int'(apple_y);
    run_i = 1'b0; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    chk(apple_vld === 1'b1, "R7 vld kept on ignored request", int'(apple_vld), 1);
    chk(int'(apple_x) == sx && int'(apple_y) == sy, "R7 position kept", int'(apple_x), sx);

    // R8: holding with no request.
    repeat (20) @(negedge clk);
    chk(int'(apple_x) == sx && int'(apple_y) == sy, "R8 position stable", int'(apple_x), sx);

    // R6 + R4: honoured request with a large occupied block.
    for (int x = 1; x <= 30; x++)
      for (int y = 0; y < GH; y++) occ_map[x * GH + y] = 1'b1;
    run_i = 1'b1; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(apple_vld === 1'b0, "R6 vld drops after honoured request", int'(apple_vld), 0);
    wait_vld(5000, "R4 apple found beside occupied block");
    chk(int'(apple_x) > 30, "R4 apple avoids occupied columns", int'(apple_x), 31);

    // R4: only one free interior cell left.
    for (int x = 0; x < GW; x++)
      for (int y = 0; y < GH; y++) occ_map[x * GH + y] = 1'b1;
    occ_map[20 * GH + 15] = 1'b0;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(apple_vld === 1'b0, "R6 new search started", int'(apple_vld), 0);
    wait_vld(60000, "R4 single free cell eventually found");
    chk(int'(apple_x) == 20, "R4 single free cell column", int'(apple_x), 20);
    chk(int'(apple_y) == 15, "R4 single free cell row", int'(apple_y), 15);

    // R5: reset while an apple is held.
    clear_map();
    rst = 1'b1;
    @(negedge clk);
    chk(apple_vld === 1'b0, "R5 vld low after mid-game reset", int'(apple_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(apple_vld === 1'b1, "R5 fresh apple after mid-game reset", int'(apple_vld), 1);
    chk(int'(apple_x) == ref_col(SEED) && int'(apple_y) == ref_row(SEED),
        "R2 first apple from seed", int'(apple_x), ref_col(SEED));

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule